// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Control

This block is the hazard logic of a five-stage in-order integer pipeline (IF, DEC, EXE, MEM, WB). Each cycle it looks at the source register numbers of the instruction sitting in DEC and compares them with the destination, write-enable and load flag of the instructions in EXE, MEM and WB. From this it picks, per source operand, where DEC should take the operand from: the register file or the result held in one of the three later stages. Because operands are bypassed into DEC, not into EXE, a result produced in EXE is usable by the very next instruction.

Loads deliver their data only once they reach WB. An instruction in DEC that depends on a load still in EXE or MEM is held, and a bubble enters EXE, until the load sits in WB; the operand is then bypassed from WB. Branches are predicted not-taken and resolved in EXE. A taken branch annuls the instructions in IF and DEC, and that annul takes precedence over any stall raised in the same cycle. A parameter builds a variant without bypass paths. In that variant every dependency on EXE, MEM or WB stalls until the producer has written back.

The block is purely combinational. It has no state of its own, so its outputs follow its inputs within the same cycle.

Top module: `hazardUnit`

## Requirements
- R1: Each operand has a 2-bit select, encoded 00 = register file, 01 = EXE result, 10 = MEM result, 11 = WB result. With no matching producer the select is 00 and stall is 0.
- R2: A used, non-zero source that equals the destination of a writing instruction in exactly one of EXE, MEM or WB gets the select of that stage, and no stall results unless R4 applies.
- R3: When several writing stages match the same source, the youngest wins: EXE over MEM over WB. This holds even when an older match is a load.
- R4: In the bypass build, a source whose youngest matching producer is a load in EXE or in MEM raises stall. The select still names that stage. A load in WB is bypassed with select 11 and raises no stall.
- R5: Source register 0 never gets a select other than 00 and never causes a stall.
- R6: Each source has a use flag (bit i for source i). A source whose use flag is 0 gets select 00 and never causes a stall.
- R7: In the no-bypass build, every select is 00, and stall is raised when any used, non-zero source matches a writing instruction in EXE, MEM or WB.
- R8: When the branch-taken input is 1, both annul outputs (for IF and for DEC) are 1. Otherwise both are 0.
- R9: A taken branch forces stall to 0 in the same cycle, even when a dependency would otherwise stall.
- R10: A stage whose write-enable is 0 never matches, whatever its destination number and load flag.
- R11: Stall is the OR of the per-operand stall needs, so a dependency on either source alone is enough.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| decSrc | input | NUM_SRC x REG_W | Source register numbers of the instruction in DEC |
| decUse | input | NUM_SRC | Per-source flag, 1 when the source is actually read |
| exeDst | input | REG_W | Destination of the instruction in EXE |
| exeWr | input | 1 | EXE instruction writes a register |
| exeLd | input | 1 | EXE instruction is a load |
| memDst | input | REG_W | Destination of the instruction in MEM |
| memWr | input | 1 | MEM instruction writes a register |
| memLd | input | 1 | MEM instruction is a load |
| wbDst | input | REG_W | Destination of the instruction in WB |
| wbWr | input | 1 | WB instruction writes a register |
| branchTaken | input | 1 | Branch in EXE resolved taken |
| srcSel | output | NUM_SRC x 2 | Per-operand bypass select (R1 encoding) |
| stall | output | 1 | Hold IF and DEC and send a bubble into EXE |
| annulIf | output | 1 | Turn the IF instruction into a bubble |
| annulDec | output | 1 | Turn the DEC instruction into a bubble |

## Verification
The two functions that can land in one cycle are the load-use stall and the taken-branch annul. Both happen when the instruction in DEC depends on a load in EXE while a branch resolves taken. The bench provokes this with a vector that pairs a load-in-EXE match with branch-taken high. It expects stall at 0, both annuls at 1, and the select still naming EXE. A second overlap, a bypass on one operand while the other operand stalls, is driven in the same table and judged per operand.

// File: rtl/hazPkg.sv
package hazPkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'b00,
    SEL_EXE = 2'b01,
    SEL_MEM = 2'b10,
    SEL_WB  = 2'b11
  } bypSel_e;

  typedef struct packed {
    logic stall;
    logic annulIf;
    logic annulDec;
  } hazStrobe_t;

endpackage

// File: rtl/hazOperand.sv
module hazOperand
  import hazPkg::*;
#(
  parameter int REG_W  = 5,
  parameter bit BYPASS = 1'b1
) (
  input  logic [REG_W-1:0] src,
  input  logic             use_,
  input  logic [REG_W-1:0] exeDst,
  input  logic             exeWr,
  input  logic             exeLd,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWr,
  input  logic             memLd,
  input  logic [REG_W-1:0] wbDst,
  input  logic             wbWr,
  output logic [SEL_W-1:0] selOut,
  output logic             mustWait
);

  logic live;
  logic hitE;
  logic hitM;
  logic hitW;

  // An operand is live only if it is read and is not the hard-wired zero register.
  assign live = use_ && (src != '0);
  assign hitE = live && exeWr && (exeDst == src);
  assign hitM = live && memWr && (memDst == src);
  assign hitW = live && wbWr  && (wbDst  == src);

  generate
    if (BYPASS) begin : gByp
      bypSel_e sel;
      always_comb begin
        sel      = SEL_RF;
        mustWait = 1'b0;
        if (hitE) begin
          sel      = SEL_EXE;
          mustWait = exeLd;
        end else if (hitM) begin
          sel      = SEL_MEM;
          mustWait = memLd;
        end else if (hitW) begin
          sel      = SEL_WB;
        end
      end
      assign selOut = sel;
    end else begin : gNoByp
      logic unusedLd;
      assign unusedLd = exeLd ^ memLd;
      assign selOut   = SEL_RF;
      assign mustWait = hitE | hitM | hitW;
    end
  endgenerate

endmodule

// File: rtl/hazOperandPath.sv
module hazOperandPath
  import hazPkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2,
  parameter bit BYPASS  = 1'b1
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] decSrc,
  input  logic [NUM_SRC-1:0]            decUse,
  input  logic [REG_W-1:0]              exeDst,
  input  logic                          exeWr,
  input  logic                          exeLd,
  input  logic [REG_W-1:0]              memDst,
  input  logic                          memWr,
  input  logic                          memLd,
  input  logic [REG_W-1:0]              wbDst,
  input  logic                          wbWr,
  output logic [NUM_SRC-1:0][SEL_W-1:0] srcSel,
  output logic [NUM_SRC-1:0]            waitVec
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : gOp
    hazOperand #(
      .REG_W (REG_W),
      .BYPASS(BYPASS)
    ) uOp (
      .src     (decSrc[i]),
      .use_    (decUse[i]),
      .exeDst  (exeDst),
      .exeWr   (exeWr),
      .exeLd   (exeLd),
      .memDst  (memDst),
      .memWr   (memWr),
      .memLd   (memLd),
      .wbDst   (wbDst),
      .wbWr    (wbWr),
      .selOut  (srcSel[i]),
      .mustWait(waitVec[i])
    );
  end

endmodule

// File: rtl/hazCtrl.sv
module hazCtrl
  import hazPkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] waitVec,
  input  logic               branchTaken,
  output hazStrobe_t         strobe
);

  always_comb begin
    strobe.annulIf  = branchTaken;
    strobe.annulDec = branchTaken;
    // The annul empties DEC, so any dependency it carried is moot.
    strobe.stall    = (|waitVec) && !branchTaken;
  end

endmodule

// File: rtl/hazardUnit.sv
module hazardUnit
  import hazPkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2,
  parameter bit BYPASS  = 1'b1
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] decSrc,
  input  logic [NUM_SRC-1:0]            decUse,
  input  logic [REG_W-1:0]              exeDst,
  input  logic                          exeWr,
  input  logic                          exeLd,
  input  logic [REG_W-1:0]              memDst,
  input  logic                          memWr,
  input  logic                          memLd,
  input  logic [REG_W-1:0]              wbDst,
  input  logic                          wbWr,
  input  logic                          branchTaken,
  output logic [NUM_SRC-1:0][1:0]       srcSel,
  output logic                          stall,
  output logic                          annulIf,
  output logic                          annulDec
);

  logic [NUM_SRC-1:0] waitVec;
  hazStrobe_t         strobe;

  hazOperandPath #(
    .REG_W  (REG_W),
    .NUM_SRC(NUM_SRC),
    .BYPASS (BYPASS)
  ) uPath (
    .decSrc (decSrc),
    .decUse (decUse),
    .exeDst (exeDst),
    .exeWr  (exeWr),
    .exeLd  (exeLd),
    .memDst (memDst),
    .memWr  (memWr),
    .memLd  (memLd),
    .wbDst  (wbDst),
    .wbWr   (wbWr),
    .srcSel (srcSel),
    .waitVec(waitVec)
  );

  hazCtrl #(
    .NUM_SRC(NUM_SRC)
  ) uCtrl (
    .waitVec    (waitVec),
    .branchTaken(branchTaken),
    .strobe     (strobe)
  );

  assign stall    = strobe.stall;
  assign annulIf  = strobe.annulIf;
  assign annulDec = strobe.annulDec;

endmodule

// File: rtl/hazardUnitChk.sv
module hazardUnitChk #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2,
  parameter bit BYPASS  = 1'b1
) (
  input logic [NUM_SRC-1:0][REG_W-1:0] decSrc,
  input logic [NUM_SRC-1:0]            decUse,
  input logic [REG_W-1:0]              exeDst,
  input logic                          exeWr,
  input logic                          exeLd,
  input logic [REG_W-1:0]              memDst,
  input logic                          memWr,
  input logic                          memLd,
  input logic [REG_W-1:0]              wbDst,
  input logic                          wbWr,
  input logic                          branchTaken,
  input logic [NUM_SRC-1:0][1:0]       srcSel,
  input logic                          stall,
  input logic                          annulIf,
  input logic                          annulDec
);

  always_comb begin
    a_r8_annul_pair: assert (annulIf == branchTaken && annulDec == branchTaken)
      else $error("annul outputs disagree with branchTaken");
    a_r9_annul_over_stall: assert (!(branchTaken && stall))
      else $error("stall raised during taken branch");
    for (int i = 0; i < NUM_SRC; i++) begin
      a_r5_zero_reg: assert (decSrc[i] != '0 || srcSel[i] == 2'b00)
        else $error("register zero bypassed");
      a_r6_unused_src: assert (decUse[i] || srcSel[i] == 2'b00)
        else $error("unused source bypassed");
      a_r7_nobyp_sel: assert (BYPASS || srcSel[i] == 2'b00)
        else $error("select nonzero without bypass paths");
      a_r4_load_exe: assert (!(BYPASS && decUse[i] && decSrc[i] != '0 && exeWr &&
                               exeLd && exeDst == decSrc[i] && !branchTaken) || stall)
        else $error("load in EXE did not stall dependent");
      a_r10_no_write_wb: assert (wbWr || srcSel[i] != 2'b11)
        else $error("WB select without WB write");
    end
  end

  logic unusedChk;
  assign unusedChk = memLd ^ (|memDst);

endmodule

bind hazardUnit hazardUnitChk #(
  .REG_W  (REG_W),
  .NUM_SRC(NUM_SRC),
  .BYPASS (BYPASS)
) uChk (
  .decSrc     (decSrc),
  .decUse     (decUse),
  .exeDst     (exeDst),
  .exeWr      (exeWr),
  .exeLd      (exeLd),
  .memDst     (memDst),
  .memWr      (memWr),
  .memLd      (memLd),
  .wbDst      (wbDst),
  .wbWr       (wbWr),
  .branchTaken(branchTaken),
  .srcSel     (srcSel),
  .stall      (stall),
  .annulIf    (annulIf),
  .annulDec   (annulDec)
);

// File: tb/tb_hazardUnit.sv
module tb_hazardUnit;

  localparam int REG_W   = 5;
  localparam int NUM_SRC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [NUM_SRC-1:0][REG_W-1:0] decSrc;
  logic [NUM_SRC-1:0]            decUse;
  logic [REG_W-1:0]              exeDst, memDst, wbDst;
  logic                          exeWr, exeLd, memWr, memLd, wbWr, branchTaken;
  logic [NUM_SRC-1:0][1:0]       srcSel, srcSelNb;
  logic                          stall, annulIf, annulDec;
  logic                          stallNb, annulIfNb, annulDecNb;

  hazardUnit #(.REG_W(REG_W), .NUM_SRC(NUM_SRC), .BYPASS(1'b1)) dut (
    .decSrc(decSrc), .decUse(decUse),
    .exeDst(exeDst), .exeWr(exeWr), .exeLd(exeLd),
    .memDst(memDst), .memWr(memWr), .memLd(memLd),
    .wbDst(wbDst), .wbWr(wbWr), .branchTaken(branchTaken),
    .srcSel(srcSel), .stall(stall), .annulIf(annulIf), .annulDec(annulDec)
  );

  hazardUnit #(.REG_W(REG_W), .NUM_SRC(NUM_SRC), .BYPASS(1'b0)) dutNb (
    .decSrc(decSrc), .decUse(decUse),
    .exeDst(exeDst), .exeWr(exeWr), .exeLd(exeLd),
    .memDst(memDst), .memWr(memWr), .memLd(memLd),
    .wbDst(wbDst), .wbWr(wbWr), .branchTaken(branchTaken),
    .srcSel(srcSelNb), .stall(stallNb), .annulIf(annulIfNb), .annulDec(annulDecNb)
  );

  typedef struct packed {
    logic [4:0] s0;
    logic [4:0] s1;
    logic [1:0] use_;
    logic [4:0] eD; logic eW; logic eL;
    logic [4:0] mD; logic mW; logic mL;
    logic [4:0] wD; logic wW;
    logic       br;
    logic [1:0] x0; logic [1:0] x1; logic xs; logic xsNb;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [0:NV-1] = '{
    // R1: idle, no writer
    '{5'd1, 5'd2, 2'b11, 5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 1'b0, 2'b00,2'b00,1'b0,1'b0, 4'd1},
    // R2: src0 from EXE, src1 from MEM
    '{5'd3, 5'd4, 2'b11, 5'd3,1'b1,1'b0, 5'd4,1'b1,1'b0, 5'd30,1'b0, 1'b0, 2'b01,2'b10,1'b0,1'b1, 4'd2},
    // R2: src0 from WB, src1 from register file
    '{5'd5, 5'd6, 2'b11, 5'd28,1'b0,1'b0, 5'd29,1'b0,1'b0, 5'd5,1'b1, 1'b0, 2'b11,2'b00,1'b0,1'b1, 4'd2},
    // R3: all three stages write src0, EXE wins
    '{5'd7, 5'd8, 2'b11, 5'd7,1'b1,1'b0, 5'd7,1'b1,1'b0, 5'd7,1'b1, 1'b0, 2'b01,2'b00,1'b0,1'b1, 4'd3},
    // R3: MEM over WB, both sources
    '{5'd9, 5'd9, 2'b11, 5'd27,1'b1,1'b0, 5'd9,1'b1,1'b0, 5'd9,1'b1, 1'b0, 2'b10,2'b10,1'b0,1'b1, 4'd3},
    // R4: load in EXE stalls
    '{5'd10, 5'd2, 2'b11, 5'd10,1'b1,1'b1, 5'd26,1'b0,1'b0, 5'd25,1'b0, 1'b0, 2'b01,2'b00,1'b1,1'b1, 4'd4},
    // R4: load in MEM stalls src1
    '{5'd12, 5'd11, 2'b11, 5'd24,1'b0,1'b0, 5'd11,1'b1,1'b1, 5'd23,1'b0, 1'b0, 2'b00,2'b10,1'b1,1'b1, 4'd4},
    // R4: load reached WB, bypass without stall
    '{5'd13, 5'd1, 2'b11, 5'd22,1'b0,1'b0, 5'd21,1'b0,1'b0, 5'd13,1'b1, 1'b0, 2'b11,2'b00,1'b0,1'b1, 4'd4},
    // R3: non-load in EXE shadows load in MEM
    '{5'd14, 5'd1, 2'b11, 5'd14,1'b1,1'b0, 5'd14,1'b1,1'b1, 5'd20,1'b0, 1'b0, 2'b01,2'b00,1'b0,1'b1, 4'd3},
    // R5: register zero everywhere
    '{5'd0, 5'd0, 2'b11, 5'd0,1'b1,1'b1, 5'd0,1'b1,1'b1, 5'd0,1'b1, 1'b0, 2'b00,2'b00,1'b0,1'b0, 4'd5},
    // R6: src0 unused despite load match
    '{5'd15, 5'd16, 2'b10, 5'd15,1'b1,1'b1, 5'd15,1'b1,1'b1, 5'd15,1'b1, 1'b0, 2'b00,2'b00,1'b0,1'b0, 4'd6},
    // R10: matching numbers but write-enables low
    '{5'd17, 5'd18, 2'b11, 5'd17,1'b0,1'b1, 5'd18,1'b0,1'b1, 5'd17,1'b0, 1'b0, 2'b00,2'b00,1'b0,1'b0, 4'd10},
    // R9: load-use and taken branch in one cycle
    '{5'd18, 5'd19, 2'b11, 5'd18,1'b1,1'b1, 5'd19,1'b1,1'b1, 5'd31,1'b0, 1'b1, 2'b01,2'b10,1'b0,1'b0, 4'd9},
    // R11: src0 bypasses from WB while src1 stalls on MEM load
    '{5'd20, 5'd21, 2'b11, 5'd3,1'b0,1'b0, 5'd21,1'b1,1'b1, 5'd20,1'b1, 1'b0, 2'b11,2'b10,1'b1,1'b1, 4'd11}
  };

  int checks = 0;
  int errors = 0;
  bit timedOut = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    decSrc[0] = v.s0; decSrc[1] = v.s1; decUse = v.use_;
    exeDst = v.eD; exeWr = v.eW; exeLd = v.eL;
    memDst = v.mD; memWr = v.mW; memLd = v.mL;
    wbDst = v.wD; wbWr = v.wW; branchTaken = v.br;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    timedOut = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    drive('0);
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: all-zero inputs give neutral outputs
    check(srcSel == '0 && !stall && !annulIf && !annulDec, "R1 idle",
          {srcSel, stall, annulIf, annulDec}, 0);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      #1 drive(VECS[i]);
      @(negedge clk);
      check(srcSel[0] == VECS[i].x0, $sformatf("R%0d vec%0d sel0", VECS[i].req, i), srcSel[0], VECS[i].x0);
      check(srcSel[1] == VECS[i].x1, $sformatf("R%0d vec%0d sel1", VECS[i].req, i), srcSel[1], VECS[i].x1);
      check(stall == VECS[i].xs, $sformatf("R%0d vec%0d stall", VECS[i].req, i), stall, VECS[i].xs);
      // R8: annuls follow branchTaken
      check(annulIf == VECS[i].br && annulDec == VECS[i].br,
            $sformatf("R8 vec%0d annul", i), {annulIf, annulDec}, {2{VECS[i].br}});
      // R7: no-bypass build
      check(srcSelNb == '0, $sformatf("R7 vec%0d nb sel", i), srcSelNb, 0);
      check(stallNb == VECS[i].xsNb, $sformatf("R7 vec%0d nb stall", i), stallNb, VECS[i].xsNb);
    end

    // R5: zero register on src1 with a writer to zero in EXE, src0 used elsewhere
    @(posedge clk);
    #1 drive('0);
    decSrc[0] = 5'd6; decSrc[1] = 5'd0; decUse = 2'b11;
    exeDst = 5'd0; exeWr = 1'b1; exeLd = 1'b1;
    @(negedge clk);
    check(srcSel[1] == 2'b00 && !stall, "R5 zero with load", {srcSel[1], stall}, 0);
    check(!stallNb, "R5 zero no-bypass", stallNb, 0);

    // R8: taken branch alone, no dependency
    @(posedge clk);
    #1 drive('0);
    branchTaken = 1'b1;
    @(negedge clk);
    check(annulIf && annulDec && !stall, "R8 branch alone", {annulIf, annulDec, stall}, 3'b110);

    // R7: no-bypass stalls on a WB-only writer, bypass build does not
    @(posedge clk);
    #1 drive('0);
    decSrc[0] = 5'd9; decUse = 2'b01; wbDst = 5'd9; wbWr = 1'b1;
    @(negedge clk);
    check(stallNb && srcSelNb[0] == 2'b00, "R7 nb WB stall", {stallNb, srcSelNb[0]}, 3'b100);
    check(!stall && srcSel[0] == 2'b11, "R2 WB bypass", {stall, srcSel[0]}, 3'b011);

    if (!timedOut) finishRun();
  end

endmodule